// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

The block turns one IEEE 754 binary32 or binary64 operand into a signed 32-bit or 64-bit integer. Five operations are offered: ceiling, floor, round-half-even, truncate, and a convert operation that follows a rounding-mode input supplied with each request. Every request is marked by `in_valid`. One clock later the integer result and two status flags are registered, and `out_valid` pulses for that one cycle.

A mode input selects one of two ways to handle operands that have no integer value or whose integer value does not fit. In standard mode, NaN gives zero and values outside the range clamp to the limit that has their sign. In legacy mode every such case returns the largest positive integer of the selected width. In both modes these cases raise the invalid flag. Any in-range result that lost a fraction raises the inexact flag.

The reset input asserts asynchronously. It is released through a two-stage synchronizer inside the block, so the first request is taken on the third rising edge after `rst_n` goes high.

Top module: `fp2int_conv`

## Requirements
- R1: `out_valid` is 1 in the cycle after each cycle in which `in_valid` is 1, and 0 after a cycle in which it is 0. Reset drives `out_valid`, `flag_invalid` and `flag_inexact` to 0.
- R2: `op_sel` 3 is ceiling (toward +inf), 4 is floor (toward -inf) and 2 is truncate (toward zero). Codes 5 to 7 also truncate.
- R3: `op_sel` 1 rounds to the nearest integer. Exact halves go to the even neighbour.
- R4: `op_sel` 0 rounds according to `rnd_mode`: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf.
- R5: With `is_double` 0, the operand is binary32 in `operand[31:0]` and `operand[63:32]` has no effect on the result. With `is_double` 1, all 64 bits form a binary64 value.
- R6: With `wide_result` 1, the result is a 64-bit two's-complement integer. With `wide_result` 0, it is a 32-bit integer sign-extended over all 64 bits of `result`.
- R7: With `nan2008` 1, a NaN operand gives result 0 and sets `flag_invalid`.
- R8: With `nan2008` 1, an operand whose rounded value exceeds the largest integer of the width gives that largest integer. One below the smallest gives the smallest integer. Infinities follow their sign. `flag_invalid` is set in both cases.
- R9: With `nan2008` 0, NaN operands, infinities and out-of-range operands of either sign all give the largest positive integer of the width and set `flag_invalid`.
- R10: `flag_inexact` is 1 exactly when the result is in range and differs from the operand's value. It is never 1 together with `flag_invalid`.
- R11: Zero, negative zero and subnormal operands convert without fault. -0.0 gives 0 with no flags. A positive subnormal gives 1 under ceiling and a negative subnormal gives -1 under floor, both inexact.
- R12: The range test is applied after rounding. For example, -2^31 fits 32 bits exactly and -2^63 fits 64 bits exactly, while 2^31, 2^63 and 2147483647.5 rounded to nearest are out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe for the operand and controls |
| operand | input | 64 | Floating-point operand (binary32 in bits 31:0) |
| is_double | input | 1 | 1 = binary64 operand, 0 = binary32 |
| wide_result | input | 1 | 1 = 64-bit result, 0 = 32-bit sign-extended |
| op_sel | input | 3 | 0 convert, 1 round, 2 truncate, 3 ceiling, 4 floor |
| rnd_mode | input | 2 | Rounding mode used by convert |
| nan2008 | input | 1 | 1 = standard NaN/overflow results, 0 = legacy |
| out_valid | output | 1 | One-cycle pulse with a new result |
| result | output | 64 | Converted integer |
| flag_invalid | output | 1 | NaN, infinite or out-of-range operand |
| flag_inexact | output | 1 | In-range result that needed rounding |

## Verification
The datapath holds no state between requests, so a fault in alignment, rounding or limit selection appears on `result` and the flags in the very cycle `out_valid` rises for the request that triggers it. A wrong rounding increment shows up as an off-by-one result on ties and near-integers. A wrong range comparison shows up at the exact powers of two and at the value just below 2^31 that rounds up. A stuck valid or flag register shows up one cycle after a request, or right after reset.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int SIG_W  = 53;          // significand with hidden bit
  localparam int EXP_W  = 13;          // signed unbiased exponent
  localparam int INT_W  = 64;          // widest integer result
  localparam int HALF_W = INT_W / 2;   // narrow integer result
  localparam int FX_W   = 2 * INT_W;   // integer + fraction fixed point

  typedef enum logic [2:0] {
    OP_CVT   = 3'd0,
    OP_RND   = 3'd1,
    OP_TRUNC = 3'd2,
    OP_CEIL  = 3'd3,
    OP_FLOOR = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unp_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [63:0] operand,
  input  logic        is_double,
  output unp_t        unp
);
  localparam int D_FW = 52;
  localparam int S_FW = 23;
  localparam int PAD  = D_FW - S_FW;

  logic [10:0]        efield;
  logic [D_FW-1:0]    frac;
  logic               emax;
  logic [EXP_W-1:0]   bias;
  logic               ezero;

  always_comb begin
    if (is_double) begin
      efield   = operand[62:52];
      frac     = operand[51:0];
      emax     = &operand[62:52];
      bias     = EXP_W'(1023);
      unp.sign = operand[63];
    end else begin
      efield   = {3'b000, operand[30:23]};
      frac     = {operand[22:0], {PAD{1'b0}}};
      emax     = &operand[30:23];
      bias     = EXP_W'(127);
      unp.sign = operand[31];
    end
    ezero      = (efield == '0);
    unp.exp    = ezero ? $signed(EXP_W'(1) - bias)
                       : $signed({2'b00, efield} - bias);
    unp.sig    = {~ezero, frac};
    unp.is_nan = emax & (|frac);
    unp.is_inf = emax & ~(|frac);
  end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
  import fp2int_pkg::*;
(
  input  logic signed [EXP_W-1:0] exp,
  input  logic [SIG_W-1:0]        sig,
  input  logic                    sign,
  input  rmode_e                  rmode,
  output logic [INT_W:0]          mag,
  output logic                    huge,
  output logic                    inexact
);
  // bit index of 2^0 inside the fixed-point word is INT_W
  localparam int SH_OFF = INT_W - (SIG_W - 1);

  logic [FX_W-1:0]  fx;
  logic [6:0]       sh;
  logic [INT_W-1:0] ipart;
  logic             guard;
  logic             sticky;
  logic             inc;

  always_comb begin
    sh     = exp[6:0] + 7'(SH_OFF);
    fx     = '0;
    huge   = 1'b0;
    ipart  = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    if (exp >= EXP_W'(INT_W)) begin
      huge = 1'b1;
    end else if (exp < -EXP_W'(1)) begin
      sticky = |sig;                 // below one half, nonzero
    end else begin
      fx     = {{(FX_W-SIG_W){1'b0}}, sig} << sh;
      ipart  = fx[FX_W-1:INT_W];
      guard  = fx[INT_W-1];
      sticky = |fx[INT_W-2:0];
    end
    unique case (rmode)
      RM_NEAR: inc = guard & (sticky | ipart[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sign & (guard | sticky);
      default: inc = sign & (guard | sticky);
    endcase
    mag     = {1'b0, ipart} + {{INT_W{1'b0}}, inc};
    inexact = guard | sticky;
  end
endmodule

// File: rtl/fp2int_limit.sv
module fp2int_limit
  import fp2int_pkg::*;
(
  input  logic             sign,
  input  logic             is_nan,
  input  logic             is_inf,
  input  logic [INT_W:0]   mag,
  input  logic             huge,
  input  logic             inexact_in,
  input  logic             wide,
  input  logic             nan2008,
  output logic [INT_W-1:0] value,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [INT_W-1:0] MAX_W = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_W = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_N = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_N = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  logic [INT_W-1:0] max_v;
  logic [INT_W-1:0] min_v;
  logic [INT_W:0]   pos_lim;
  logic [INT_W:0]   neg_lim;
  logic             over;

  always_comb begin
    max_v   = wide ? MAX_W : MAX_N;
    min_v   = wide ? MIN_W : MIN_N;
    pos_lim = {1'b0, max_v};
    neg_lim = pos_lim + 1'b1;
    over    = huge | is_inf | (sign ? (mag > neg_lim) : (mag > pos_lim));
    invalid = 1'b0;
    inexact = 1'b0;
    if (is_nan) begin
      invalid = 1'b1;
      value   = nan2008 ? '0 : max_v;
    end else if (over) begin
      invalid = 1'b1;
      value   = (nan2008 && sign) ? min_v : max_v;
    end else begin
      inexact = inexact_in;
      value   = sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
    end
  end
endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fp2int_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [63:0]      operand,
  input  logic             is_double,
  input  logic             wide_result,
  input  logic [2:0]       op_sel,
  input  logic [1:0]       rnd_mode,
  input  logic             nan2008,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_inexact
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // datapath
  unp_t             unp;
  rmode_e           eff_rm;
  logic [INT_W:0]   mag;
  logic             huge;
  logic             rnd_inexact;
  logic [INT_W-1:0] conv_value;
  logic             conv_invalid;
  logic             conv_inexact;

  always_comb begin
    unique case (op_sel)
      OP_CVT:   eff_rm = rmode_e'(rnd_mode);
      OP_RND:   eff_rm = RM_NEAR;
      OP_CEIL:  eff_rm = RM_UP;
      OP_FLOOR: eff_rm = RM_DOWN;
      default:  eff_rm = RM_ZERO;
    endcase
  end

  fp2int_unpack i_unpack (
    .operand   (operand),
    .is_double (is_double),
    .unp       (unp)
  );

  fp2int_round i_round (
    .exp     (unp.exp),
    .sig     (unp.sig),
    .sign    (unp.sign),
    .rmode   (eff_rm),
    .mag     (mag),
    .huge    (huge),
    .inexact (rnd_inexact)
  );

  fp2int_limit i_limit (
    .sign       (unp.sign),
    .is_nan     (unp.is_nan),
    .is_inf     (unp.is_inf),
    .mag        (mag),
    .huge       (huge),
    .inexact_in (rnd_inexact),
    .wide       (wide_result),
    .nan2008    (nan2008),
    .value      (conv_value),
    .invalid    (conv_invalid),
    .inexact    (conv_inexact)
  );

  // next-state
  logic [INT_W-1:0] result_d;
  logic             inv_d;
  logic             inx_d;

  always_comb begin
    result_d = result;
    inv_d    = flag_invalid;
    inx_d    = flag_inexact;
    if (in_valid) begin
      result_d = conv_value;
      inv_d    = conv_invalid;
      inx_d    = conv_inexact;
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      result       <= result_d;
      flag_invalid <= inv_d;
      flag_inexact <= inx_d;
    end
  end

  // port-level operand classification for the checks below
  logic in_nan;
  assign in_nan = is_double ? (&operand[62:52] & |operand[51:0])
                            : (&operand[30:23] & |operand[22:0]);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> out_valid);

  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> !out_valid);

  a_r7_nan_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && nan2008 && in_nan) |=> (result == '0 && flag_invalid));

  a_r9_legacy_max: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && !nan2008) |=> (!flag_invalid ||
      result == ($past(wide_result) ? {1'b0, {(INT_W-1){1'b1}}}
                                    : {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}})));

  a_r6_narrow_sext: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && !wide_result) |=>
      ((&result[INT_W-1:HALF_W-1]) || !(|result[INT_W-1:HALF_W-1])));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> !(flag_invalid && flag_inexact));
endmodule

// File: tb/test_fp2int_conv.sv
`timescale 1ns/1ps
module test_fp2int_conv;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] operand;
  logic        is_double;
  logic        wide_result;
  logic [2:0]  op_sel;
  logic [1:0]  rnd_mode;
  logic        nan2008;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_invalid;
  logic        flag_inexact;

  int checks;
  int failures;
  bit done;

  fp2int_conv i_fp2int_conv (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .operand      (operand),
    .is_double    (is_double),
    .wide_result  (wide_result),
    .op_sel       (op_sel),
    .rnd_mode     (rnd_mode),
    .nan2008      (nan2008),
    .out_valid    (out_valid),
    .result       (result),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  typedef struct packed {
    logic [63:0] opnd;
    logic        dbl;
    logic        wide;
    logic [2:0]  op;
    logic [1:0]  rm;
    logic        n08;
    logic [63:0] exp_res;
    logic        exp_inv;
    logic        exp_inx;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  // op: 0 cvt, 1 round, 2 trunc, 3 ceil, 4 floor; rm: 0 near, 1 zero, 2 up, 3 down
  localparam vec_t VECS [0:NV-1] = '{
    '{64'h3FF8000000000000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 64'h0000000000000002, 1'b0, 1'b1, 8'd3},  // R3 1.5
    '{64'h4004000000000000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 64'h0000000000000002, 1'b0, 1'b1, 8'd3},  // R3 2.5
    '{64'hBFF8000000000000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 8'd3},  // R3 -1.5
    '{64'hC004000000000000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 8'd3},  // R3 -2.5
    '{64'h4004000000000000, 1'b1, 1'b1, 3'd0, 2'd0, 1'b1, 64'h0000000000000002, 1'b0, 1'b1, 8'd4},  // R4 near
    '{64'h4004000000000000, 1'b1, 1'b1, 3'd0, 2'd2, 1'b1, 64'h0000000000000003, 1'b0, 1'b1, 8'd4},  // R4 up
    '{64'hC004000000000000, 1'b1, 1'b1, 3'd0, 2'd3, 1'b1, 64'hFFFFFFFFFFFFFFFD, 1'b0, 1'b1, 8'd4},  // R4 down
    '{64'hC004000000000000, 1'b1, 1'b1, 3'd0, 2'd1, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 8'd4},  // R4 zero
    '{64'h3FF8000000000000, 1'b1, 1'b1, 3'd3, 2'd0, 1'b1, 64'h0000000000000002, 1'b0, 1'b1, 8'd2},  // R2 ceil
    '{64'hBFF8000000000000, 1'b1, 1'b1, 3'd4, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 8'd2},  // R2 floor
    '{64'h00000000C0300000, 1'b0, 1'b0, 3'd2, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 8'd2},  // R2 trunc -2.75
    '{64'h00000000C0300000, 1'b0, 1'b0, 3'd3, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFE, 1'b0, 1'b1, 8'd2},  // R2 ceil -2.75
    '{64'h0000000040300000, 1'b0, 1'b0, 3'd4, 2'd0, 1'b1, 64'h0000000000000002, 1'b0, 1'b1, 8'd2},  // R2 floor 2.75
    '{64'hDEADBEEF3FC00000, 1'b0, 1'b0, 3'd2, 2'd0, 1'b1, 64'h0000000000000001, 1'b0, 1'b1, 8'd5},  // R5 upper ignored
    '{64'h4202A05F20000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b1, 64'h00000002540BE400, 1'b0, 1'b0, 8'd6},  // R6 1e10 wide
    '{64'h4202A05F20000000, 1'b1, 1'b0, 3'd2, 2'd0, 1'b1, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd8},  // R8 +over
    '{64'hC202A05F20000000, 1'b1, 1'b0, 3'd2, 2'd0, 1'b1, 64'hFFFFFFFF80000000, 1'b1, 1'b0, 8'd8},  // R8 -over
    '{64'hC202A05F20000000, 1'b1, 1'b0, 3'd2, 2'd0, 1'b0, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd9},  // R9 -over
    '{64'h7FF8000000000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b1, 64'h0000000000000000, 1'b1, 1'b0, 8'd7},  // R7 dbl NaN
    '{64'h000000007FC00000, 1'b0, 1'b0, 3'd1, 2'd0, 1'b1, 64'h0000000000000000, 1'b1, 1'b0, 8'd7},  // R7 sgl NaN
    '{64'h7FF8000000000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b0, 64'h7FFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd9},  // R9 NaN
    '{64'hFFF0000000000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b1, 64'h8000000000000000, 1'b1, 1'b0, 8'd8},  // R8 -inf
    '{64'hFFF0000000000000, 1'b1, 1'b0, 3'd4, 2'd0, 1'b0, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd9},  // R9 -inf
    '{64'h000000007F800000, 1'b0, 1'b0, 3'd3, 2'd0, 1'b1, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd8},  // R8 +inf
    '{64'hC1E0000000000000, 1'b1, 1'b0, 3'd2, 2'd0, 1'b1, 64'hFFFFFFFF80000000, 1'b0, 1'b0, 8'd12}, // R12 -2^31
    '{64'h41E0000000000000, 1'b1, 1'b0, 3'd2, 2'd0, 1'b1, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd12}, // R12 2^31
    '{64'h41DFFFFFFFE00000, 1'b1, 1'b0, 3'd1, 2'd0, 1'b1, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd12}, // R12 round-up over
    '{64'h41DFFFFFFFE00000, 1'b1, 1'b0, 3'd2, 2'd0, 1'b1, 64'h000000007FFFFFFF, 1'b0, 1'b1, 8'd10}, // R10 trunc fits
    '{64'hC3E0000000000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b1, 64'h8000000000000000, 1'b0, 1'b0, 8'd12}, // R12 -2^63
    '{64'h43E0000000000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b0, 64'h7FFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd12}, // R12 2^63
    '{64'h0000000000000001, 1'b1, 1'b1, 3'd3, 2'd0, 1'b1, 64'h0000000000000001, 1'b0, 1'b1, 8'd11}, // R11 +sub ceil
    '{64'h8000000000000001, 1'b1, 1'b1, 3'd4, 2'd0, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd11}, // R11 -sub floor
    '{64'h8000000000000000, 1'b1, 1'b1, 3'd4, 2'd0, 1'b1, 64'h0000000000000000, 1'b0, 1'b0, 8'd11}, // R11 -0.0
    '{64'h0000000000000001, 1'b0, 1'b0, 3'd3, 2'd0, 1'b1, 64'h0000000000000001, 1'b0, 1'b1, 8'd11}, // R11 sgl sub
    '{64'h3FE0000000000000, 1'b1, 1'b1, 3'd1, 2'd0, 1'b1, 64'h0000000000000000, 1'b0, 1'b1, 8'd10}, // R10 0.5
    '{64'h4000000000000000, 1'b1, 1'b1, 3'd2, 2'd0, 1'b1, 64'h0000000000000002, 1'b0, 1'b0, 8'd10}  // R10 exact
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      summary();
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; is_double = 1'b1;
    wide_result = 1'b1; op_sel = 3'd2; rnd_mode = 2'd0; nan2008 = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0 && flag_invalid == 1'b0 && flag_inexact == 1'b0,
          "R1", "reset state", {61'd0, out_valid, flag_invalid, flag_inexact}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      operand     = VECS[i].opnd;
      is_double   = VECS[i].dbl;
      wide_result = VECS[i].wide;
      op_sel      = VECS[i].op;
      rnd_mode    = VECS[i].rm;
      nan2008     = VECS[i].n08;
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
      check(out_valid == 1'b1, "R1", "out_valid after request", {63'd0, out_valid}, 64'd1);
      if (result !== VECS[i].exp_res || flag_invalid !== VECS[i].exp_inv ||
          flag_inexact !== VECS[i].exp_inx) begin
        checks++;
        failures++;
        $display("FAIL R%0d vector %0d actual=%h inv=%b inx=%b expected=%h inv=%b inx=%b",
                 VECS[i].req, i, result, flag_invalid, flag_inexact,
                 VECS[i].exp_res, VECS[i].exp_inv, VECS[i].exp_inx);
      end else begin
        checks++;
      end
    end

    // R1 pulse ends when no request follows
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid drops", {63'd0, out_valid}, 64'd0);

    // R5 upper half changes only: same result for different junk
    operand = 64'h123456783FC00000; is_double = 1'b0; wide_result = 1'b0;
    op_sel = 3'd6; nan2008 = 1'b1; in_valid = 1'b1;   // R2 code 6 truncates
    @(negedge clk);
    in_valid = 1'b0;
    check(result == 64'd1 && flag_inexact == 1'b1, "R5", "junk upper bits, op 6",
          result, 64'd1);

    // R1 reset clears flags after an invalid result
    operand = 64'h7FF8000000000000; is_double = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(flag_invalid == 1'b1, "R7", "invalid before reset", {63'd0, flag_invalid}, 64'd1);
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0 && flag_invalid == 1'b0 && flag_inexact == 1'b0,
          "R1", "mid-run reset", {61'd0, out_valid, flag_invalid, flag_inexact}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule